// File: doc/BRIEF.md
# Register File and ALU Execution Datapath

This block is the execution half of a small multicycle processor. It keeps eight 16-bit general registers behind a single read port and a single write port, two operand holding registers filled from that read port, a one-bit shifter placed in front of the ALU on the second operand, and a three-bit status register. The block makes no decisions of its own. An external sequencer drives every register select, load enable, operation code and write-back choice, one step per clock.

A typical instruction takes these steps. The sequencer reads a source register into operand A, reads a second source into operand B, holds the operation and shift codes, and then enables the write port. The write-back value is either the ALU result or an 8-bit immediate widened with its sign bit. A compare does no write-back. It loads the negative, overflow and zero flags instead, and those flags stay frozen through every other operation.

Top module: `regalu_datapath`

## Requirements
- R1: After reset the operand registers and the flags are zero, so with operation code 001 (add) and shift code 00 the ALU output reads 0x0000 and all three flags read 0.
- R2: A general register takes the write-back value on a rising clock edge only when `wr_en` is high. With `wr_en` low, the register's contents do not change, which is visible on `rd_data`.
- R3: When `wb_imm` is high, the write-back value is `imm8` sign-extended to 16 bits: 0x07 gives 0x0007 and 0x80 gives 0xFF80.
- R4: Shift code 00 passes operand B unchanged. Code 01 shifts it left by one and fills with zero. Code 10 shifts it right by one and fills with zero. Code 11 shifts it right by one and copies the sign bit.
- R5: Operation code 001 outputs A + shift(B), for example 2 + (7 shifted left) = 0x0010.
- R6: Operation code 010 (compare) outputs A − shift(B). When `flag_ld` is high, it loads the flags on the clock edge: N is the result's MSB, Z is set when the result is zero, and V is set when A and shift(B) differ in sign and the result's sign differs from A.
- R7: Operation code 011 outputs A & shift(B), for example 7 & 2 = 2.
- R8: Operation code 100 outputs ~shift(B), and operand A has no effect on it.
- R9: Operation code 000 (move) outputs shift(B), and operand A has no effect on it.
- R10: The flags hold their value on any edge where the operation is not compare or `flag_ld` is low.
- R11: Operands A and B load `rd_data` on a rising edge only while `ld_a` or `ld_b` respectively is high. Otherwise they hold, and the ALU output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel | input | 3 | Read port register select |
| ld_a | input | 1 | Load operand A from the read port |
| ld_b | input | 1 | Load operand B from the read port |
| shift_op | input | 2 | Shift code for operand B |
| alu_op | input | 3 | ALU operation code |
| flag_ld | input | 1 | Load flags (effective with compare only) |
| wb_imm | input | 1 | Write-back select: 1 immediate, 0 ALU |
| imm8 | input | 8 | Immediate value |
| wr_sel | input | 3 | Write port register select |
| wr_en | input | 1 | Write enable for the register bank |
| rd_data | output | 16 | Read port data (combinational) |
| alu_y | output | 16 | ALU result (combinational from the operands) |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |

## Verification
A corrupted general register shows on `rd_data` in the same cycle it is selected. It also reaches `alu_y` one edge after the value is latched into an operand. A wrong operand or shift code changes `alu_y` combinationally, before any edge. Flag corruption is held state, so it stays visible on the flag pins until the next compare with `flag_ld`. For that reason the bench checks the flags both after non-compare operations and after a compare with `flag_ld` low.

// File: rtl/dpath_pkg.sv
`timescale 1ns/1ps
package dpath_pkg;
  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_NOT  = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_LSL  = 2'd1,
    SH_LSR  = 2'd2,
    SH_ASR  = 2'd3
  } shift_e;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic zero;
  } flags_t;
endpackage

// File: rtl/dp_regbank.sv
`timescale 1ns/1ps
module dp_regbank #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word_q [NREG];
  logic [NREG-1:0]   we_vec;

  // one-hot write enable per word
  always_comb begin
    we_vec = '0;
    if (wr_en) we_vec[wr_sel] = 1'b1;
  end

  // storage words carry no reset: contents are unknown until written
  for (genvar g = 0; g < NREG; g++) begin : g_word
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;
    always_comb d = we_vec[g] ? wr_data : q;
    always_ff @(posedge clk) q <= d;
    assign word_q[g] = q;
  end

  assign rd_data = word_q[rd_sel];

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (word_q[$past(wr_sel)] == $past(wr_data)));
endmodule

// File: rtl/dp_shifter.sv
`timescale 1ns/1ps
module dp_shifter
  import dpath_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        code,
  output logic [DATA_W-1:0] dout
);
  always_comb begin
    case (shift_e'(code))
      SH_LSL:  dout = {din[DATA_W-2:0], 1'b0};
      SH_LSR:  dout = {1'b0, din[DATA_W-1:1]};
      SH_ASR:  dout = {din[DATA_W-1], din[DATA_W-1:1]};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
`timescale 1ns/1ps
module dp_alu
  import dpath_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [2:0]        op,
  output logic [DATA_W-1:0] y,
  output flags_t            cmp_flags
);
  localparam int MSB = DATA_W - 1;

  logic              do_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum;

  // one shared adder: subtract by inverting b and carrying in one
  always_comb begin
    do_sub = (alu_op_e'(op) == OP_SUB);
    b_eff  = do_sub ? ~b : b;
    sum    = a + b_eff + {{(DATA_W-1){1'b0}}, do_sub};
  end

  always_comb begin
    case (alu_op_e'(op))
      OP_ADD:  y = sum;
      OP_SUB:  y = sum;
      OP_AND:  y = a & b;
      OP_NOT:  y = ~b;
      default: y = b;
    endcase
  end

  // flag candidates, always from the subtraction path
  always_comb begin
    cmp_flags.neg  = sum[MSB];
    cmp_flags.zero = (sum == '0);
    cmp_flags.ovf  = (a[MSB] ^ b[MSB]) & (sum[MSB] ^ a[MSB]);
  end
endmodule

// File: rtl/regalu_datapath.sv
`timescale 1ns/1ps
module regalu_datapath
  import dpath_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int IMM_W  = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic [1:0]        shift_op,
  input  logic [2:0]        alu_op,
  input  logic              flag_ld,
  input  logic              wb_imm,
  input  logic [IMM_W-1:0]  imm8,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] alu_y,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_z
);
  logic [DATA_W-1:0] opa_q, opa_d;
  logic [DATA_W-1:0] opb_q, opb_d;
  logic [DATA_W-1:0] opb_sh;
  logic [DATA_W-1:0] wb_data;
  logic [DATA_W-1:0] imm_ext;
  flags_t            flg_q, flg_d, cmp_flags;
  logic              flg_en;

  dp_regbank #(.DATA_W(DATA_W), .NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_sel  (rd_sel),
    .wr_sel  (wr_sel),
    .wr_en   (wr_en),
    .wr_data (wb_data),
    .rd_data (rd_data)
  );

  // operand next-state with explicit enables
  always_comb begin
    opa_d = ld_a ? rd_data : opa_q;
    opb_d = ld_b ? rd_data : opb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else begin
      opa_q <= opa_d;
      opb_q <= opb_d;
    end
  end

  dp_shifter #(.DATA_W(DATA_W)) u_shift (
    .din  (opb_q),
    .code (shift_op),
    .dout (opb_sh)
  );

  dp_alu #(.DATA_W(DATA_W)) u_alu (
    .a         (opa_q),
    .b         (opb_sh),
    .op        (alu_op),
    .y         (alu_y),
    .cmp_flags (cmp_flags)
  );

  // status register loads only on a compare step
  always_comb begin
    flg_en = flag_ld && (alu_op_e'(alu_op) == OP_SUB);
    flg_d  = flg_en ? cmp_flags : flg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flag_n = flg_q.neg;
  assign flag_v = flg_q.ovf;
  assign flag_z = flg_q.zero;

  // write-back selection
  always_comb begin
    imm_ext = {{(DATA_W-IMM_W){imm8[IMM_W-1]}}, imm8};
    wb_data = wb_imm ? imm_ext : alu_y;
  end

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_ld && alu_op == 3'd2) |=> $stable({flag_n, flag_v, flag_z}));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ld && alu_op == 3'd2) |=> (flag_z == ($past(alu_y) == '0)));

  assert_opa_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_a |=> $stable(opa_q));

  assert_opb_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_b |=> $stable(opb_q));
endmodule

// File: tb/regalu_datapath_bench.sv
`timescale 1ns/1ps
module regalu_datapath_bench;
  logic        clk;
  logic        rst_n;
  logic [2:0]  rd_sel;
  logic        ld_a;
  logic        ld_b;
  logic [1:0]  shift_op;
  logic [2:0]  alu_op;
  logic        flag_ld;
  logic        wb_imm;
  logic [7:0]  imm8;
  logic [2:0]  wr_sel;
  logic        wr_en;
  logic [15:0] rd_data;
  logic [15:0] alu_y;
  logic        flag_n, flag_v, flag_z;

  regalu_datapath u_regalu_datapath (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .ld_a(ld_a), .ld_b(ld_b),
    .shift_op(shift_op), .alu_op(alu_op), .flag_ld(flag_ld), .wb_imm(wb_imm),
    .imm8(imm8), .wr_sel(wr_sel), .wr_en(wr_en), .rd_data(rd_data),
    .alu_y(alu_y), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    string       req;
    int          sel;   // 0 rd_data, 1 alu_y, 2 flags {n,v,z}
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  // monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.sel)
          0:       act = rd_data;
          1:       act = alu_y;
          default: act = {13'd0, flag_n, flag_v, flag_z};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic push(input string req, input int sel, input logic [15:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
    -> chk_ev;
    #0.2;
  endtask

  task automatic wr_imm(input logic [2:0] dst, input logic [7:0] v);
    @(negedge clk); wb_imm = 1'b1; imm8 = v; wr_sel = dst; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wb_alu(input logic [2:0] dst);
    @(negedge clk); wb_imm = 1'b0; wr_sel = dst; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_chk(input logic [2:0] r, input logic [15:0] exp, input string req);
    @(negedge clk); rd_sel = r; #0.5;
    push(req, 0, exp);
  endtask

  task automatic load_ab(input logic [2:0] ra, input logic [2:0] rb);
    @(negedge clk); rd_sel = ra; ld_a = 1'b1;
    @(negedge clk); ld_a = 1'b0; rd_sel = rb; ld_b = 1'b1;
    @(negedge clk); ld_b = 1'b0;
  endtask

  task automatic alu_chk(input logic [2:0] op, input logic [1:0] sh,
                         input logic [15:0] exp, input string req);
    @(negedge clk); alu_op = op; shift_op = sh; #0.5;
    push(req, 1, exp);
  endtask

  task automatic flag_step(input logic [2:0] op, input logic [1:0] sh, input logic fl,
                           input logic [2:0] exp, input string req);
    @(negedge clk); alu_op = op; shift_op = sh; flag_ld = fl;
    @(negedge clk); flag_ld = 1'b0; #0.5;
    push(req, 2, {13'd0, exp});
  endtask

  initial begin
    rst_n = 1'b0; rd_sel = '0; ld_a = 0; ld_b = 0; shift_op = '0; alu_op = 3'd1;
    flag_ld = 0; wb_imm = 0; imm8 = '0; wr_sel = '0; wr_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.5;
    push("R1 alu after reset", 1, 16'h0000);
    push("R1 flags after reset", 2, 16'h0000);

    wr_imm(3'd0, 8'h07);
    wr_imm(3'd1, 8'h02);
    read_chk(3'd0, 16'h0007, "R3 imm 0x07");
    read_chk(3'd1, 16'h0002, "R2 write R1");
    // write attempt with wr_en low
    @(negedge clk); wb_imm = 1'b1; imm8 = 8'h55; wr_sel = 3'd0; wr_en = 1'b0;
    @(negedge clk);
    read_chk(3'd0, 16'h0007, "R2 no write when disabled");
    wr_imm(3'd3, 8'h80);
    read_chk(3'd3, 16'hFF80, "R3 imm sign extension");

    load_ab(3'd1, 3'd0);                       // A=2 B=7
    alu_chk(3'd1, 2'd1, 16'h0010, "R5 add with left shift");
    wb_alu(3'd2);
    read_chk(3'd2, 16'h0010, "R2 alu write-back");

    load_ab(3'd0, 3'd1);                       // A=7 B=2
    alu_chk(3'd3, 2'd0, 16'h0002, "R7 and");
    alu_chk(3'd4, 2'd0, 16'hFFFD, "R8 not ignores A");
    wb_alu(3'd5);
    read_chk(3'd5, 16'hFFFD, "R8 not written back");
    // R11: enables low while the read port moves
    @(negedge clk); rd_sel = 3'd3;
    @(negedge clk);
    alu_chk(3'd3, 2'd0, 16'h0002, "R11 operands held");

    load_ab(3'd5, 3'd1);                       // A=FFFD B=2
    alu_chk(3'd2, 2'd0, 16'hFFFB, "R6 compare difference");
    flag_step(3'd2, 2'd0, 1'b1, 3'b100, "R6 compare flags negative");

    wr_imm(3'd4, 8'h81);                       // FF81
    load_ab(3'd0, 3'd4);                       // A=7 B=FF81
    alu_chk(3'd0, 2'd0, 16'hFF81, "R9 move ignores A");
    alu_chk(3'd0, 2'd1, 16'hFF02, "R4 left shift");
    alu_chk(3'd0, 2'd3, 16'hFFC0, "R4 arithmetic right shift");
    alu_chk(3'd0, 2'd2, 16'h7FC0, "R4 logical right shift");
    wb_alu(3'd6);
    read_chk(3'd6, 16'h7FC0, "R2 shifted write-back");

    load_ab(3'd6, 3'd3);                       // A=7FC0 B=FF80
    alu_chk(3'd2, 2'd1, 16'h80C0, "R6 compare overflow diff");
    flag_step(3'd2, 2'd1, 1'b1, 3'b110, "R6 overflow flag");
    flag_step(3'd1, 2'd0, 1'b1, 3'b110, "R10 add leaves flags");

    load_ab(3'd0, 3'd0);                       // A=7 B=7
    flag_step(3'd2, 2'd0, 1'b0, 3'b110, "R10 compare without load");
    flag_step(3'd2, 2'd0, 1'b1, 3'b001, "R6 zero flag");

    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule